// File: doc/BRIEF.md
# Atomic Test-and-Set Lock Unit

This unit sits on the memory side of a split-transaction bus. It holds a small array of one-bit lock flags. On such a bus a read-modify-write is normally issued as a read and, some time later, a write. Queues can hold many pending requests to many locations, so another master's access to the same flag can land between those two halves and break the lock.

Here the whole test-and-set is one indivisible hardware action. In a single clock the addressed flag is read and set to 1. The prior value comes back in a completion one cycle later, where 0 means the requester now owns the lock. The unit takes requests from an in-order queued stream, one per cycle. It applies each request to the flag array in arrival order, so no two requests ever see the same intermediate state.

Besides test-and-set, the stream can carry two other kinds of request. A clear releases a lock and is write-only. A plain read returns a flag without changing it. Every completion carries the requester ID and tag of the request it answers, so the bus can route it back.

Top module: `tas_lock_unit`

## Requirements
- R1: After reset every flag reads 0 and `cpl_valid` is low.
- R2: A test-and-set request (`req_op` = 2'b01) returns the prior flag value in `cpl_old` and leaves the flag at 1.
- R3: A clear request (`req_op` = 2'b10) sets the flag to 0 and produces no completion.
- R4: A plain read request (`req_op` = 2'b00) returns the flag value and leaves the flag unchanged.
- R5: The reserved code (`req_op` = 2'b11) changes no flag and produces no completion.
- R6: Requests take effect in arrival order, one per cycle. Of two back-to-back test-and-sets to one flag, only the first can return 0.
- R7: A request that needs a reply (read or test-and-set) gets `cpl_valid` exactly one cycle after it is accepted. `cpl_id` and `cpl_tag` equal that request's `req_id` and `req_tag`.
- R8: A request changes only the flag selected by `req_addr`. The highest address behaves like any other address.
- R9: A cycle with `req_valid` low produces no completion in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 read, 01 test-and-set, 10 clear, 11 reserved |
| req_addr | input | ADDR_W | Flag index |
| req_id | input | ID_W | Requester ID |
| req_tag | input | TAG_W | Requester transaction tag |
| cpl_valid | output | 1 | Completion present |
| cpl_id | output | ID_W | ID echoed from the request |
| cpl_tag | output | TAG_W | Tag echoed from the request |
| cpl_old | output | 1 | Flag value before the request |

## Verification
A flag left in the wrong state does not show at once. It shows on the next read or test-and-set to that same flag, one cycle after that request, as a wrong `cpl_old`. For that reason the stimulus always follows each state change with an access to the same flag, and checks neighbouring flags as well. Errors in the completion path, such as a lost or duplicated reply or a stale ID or tag, show within one cycle. The bench model predicts the completion for every cycle and compares it.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_TAS   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_RSVD  = 2'b11
  } lock_op_e;
endpackage

// File: rtl/lock_op_decode.sv
module lock_op_decode
  import tas_lock_pkg::*;
(
  input  logic     valid,
  input  lock_op_e op,
  output logic     do_set,
  output logic     do_clr,
  output logic     do_reply
);
  always_comb begin
    do_set   = 1'b0;
    do_clr   = 1'b0;
    do_reply = 1'b0;
    if (valid) begin
      unique case (op)
        OP_READ:  do_reply = 1'b1;
        OP_TAS:   begin do_set = 1'b1; do_reply = 1'b1; end
        OP_CLEAR: do_clr = 1'b1;
        OP_RSVD:  ;
      endcase
    end
  end
endmodule

// File: rtl/lock_flag_array.sv
module lock_flag_array #(
  parameter int NUM_FLAGS = 16,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              set_en,
  input  logic              clr_en,
  output logic              old_bit
);
  logic [NUM_FLAGS-1:0] flags;
  logic                 in_range;

  assign in_range = (32'(addr) < NUM_FLAGS);
  // read-first: the value seen is the one before this cycle's write
  assign old_bit  = in_range ? flags[addr] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (in_range) begin
      if (set_en)      flags[addr] <= 1'b1;
      else if (clr_en) flags[addr] <= 1'b0;
    end
  end
endmodule

// File: rtl/lock_cpl_reg.sv
module lock_cpl_reg #(
  parameter int ID_W  = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ID_W-1:0]  id_in,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             old_in,
  output logic             valid_q,
  output logic [ID_W-1:0]  id_q,
  output logic [TAG_W-1:0] tag_q,
  output logic             old_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      id_q    <= '0;
      tag_q   <= '0;
      old_q   <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) begin
        id_q  <= id_in;
        tag_q <= tag_in;
        old_q <= old_in;
      end
    end
  end
endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit
  import tas_lock_pkg::*;
#(
  parameter int NUM_FLAGS = 16,
  parameter int ID_W      = 4,
  parameter int TAG_W     = 6,
  localparam int ADDR_W   = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              cpl_valid,
  output logic [ID_W-1:0]   cpl_id,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic              cpl_old
);
  logic do_set, do_clr, do_reply, old_bit;

  lock_op_decode u_dec (
    .valid    (req_valid),
    .op       (lock_op_e'(req_op)),
    .do_set   (do_set),
    .do_clr   (do_clr),
    .do_reply (do_reply)
  );

  lock_flag_array #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .addr    (req_addr),
    .set_en  (do_set),
    .clr_en  (do_clr),
    .old_bit (old_bit)
  );

  lock_cpl_reg #(.ID_W(ID_W), .TAG_W(TAG_W)) u_cpl (
    .clk     (clk),
    .rst     (rst),
    .load    (do_reply),
    .id_in   (req_id),
    .tag_in  (req_tag),
    .old_in  (old_bit),
    .valid_q (cpl_valid),
    .id_q    (cpl_id),
    .tag_q   (cpl_tag),
    .old_q   (cpl_old)
  );
endmodule

// File: rtl/tas_lock_unit_chk.sv
module tas_lock_unit_chk #(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 4,
  parameter int TAG_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ID_W-1:0]   req_id,
  input logic [TAG_W-1:0]  req_tag,
  input logic              cpl_valid,
  input logic [ID_W-1:0]   cpl_id,
  input logic [TAG_W-1:0]  cpl_tag,
  input logic              cpl_old
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !cpl_valid);

  // R7
  reply_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 2'b00 || req_op == 2'b01)) |=>
      (cpl_valid && cpl_id == $past(req_id) && cpl_tag == $past(req_tag)));

  // R3
  clear_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b10) |=> !cpl_valid);

  // R5
  rsvd_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b11) |=> !cpl_valid);

  // R9
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !cpl_valid);

  // R6
  second_tas_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b01 && $past(req_valid) && $past(req_op) == 2'b01 &&
     req_addr == $past(req_addr) && !$past(rst)) |=> cpl_old);
endmodule

bind tas_lock_unit tas_lock_unit_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
  .req_id(req_id), .req_tag(req_tag), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
  .cpl_tag(cpl_tag), .cpl_old(cpl_old)
);

// File: tb/tas_lock_unit_test.sv
module tas_lock_unit_test;
  localparam int NF = 16;
  localparam int AW = 4;
  localparam int IW = 4;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [IW-1:0] req_id = '0;
  logic [TW-1:0] req_tag = '0;
  logic cpl_valid, cpl_old;
  logic [IW-1:0] cpl_id;
  logic [TW-1:0] cpl_tag;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit ref_flags [NF];

  always #2.5 clk = ~clk;

  tas_lock_unit #(.NUM_FLAGS(NF), .ID_W(IW), .TAG_W(TW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_id(req_id), .req_tag(req_tag), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
    .cpl_tag(cpl_tag), .cpl_old(cpl_old)
  );

  task automatic check(input bit ok, input string rq, input string what, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, got, exp);
    end
  endtask

  // drive one request, advance one clock with the model, compare the completion
  task automatic step(input bit v, input int op, input int a, input int id, input int tg, input string rq);
    bit ev, eo;
    @(negedge clk);
    req_valid = v;
    req_op    = op[1:0];
    req_addr  = a[AW-1:0];
    req_id    = id[IW-1:0];
    req_tag   = tg[TW-1:0];
    ev = v && (op == 0 || op == 1);
    eo = ref_flags[a];
    if (v && op == 1) ref_flags[a] = 1'b1;
    if (v && op == 2) ref_flags[a] = 1'b0;
    @(posedge clk);
    #1;
    check(cpl_valid == ev, rq, "cpl_valid", int'(cpl_valid), int'(ev));
    if (ev) begin
      check(cpl_old == eo, rq, "cpl_old", int'(cpl_old), int'(eo));
      check(cpl_id == id[IW-1:0], rq, "cpl_id", int'(cpl_id), id % (1 << IW));
      check(cpl_tag == tg[TW-1:0], rq, "cpl_tag", int'(cpl_tag), tg % (1 << TW));
    end
  endtask

  initial begin
    #(5 * 100000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (ref_flags[i]) ref_flags[i] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(cpl_valid == 1'b0, "R1", "cpl_valid after reset", int'(cpl_valid), 0);
    for (int i = 0; i < NF; i++) step(1, 0, i, i, i, "R1");
    // R2 / R6: acquire then contend back to back
    step(1, 1, 3, 1, 10, "R2");
    step(1, 1, 3, 2, 11, "R6");
    step(1, 0, 3, 3, 12, "R4");
    step(1, 0, 4, 3, 13, "R8");
    step(1, 0, 2, 3, 14, "R8");
    // R3 release then observe
    step(1, 2, 3, 4, 15, "R3");
    step(1, 0, 3, 4, 16, "R3");
    step(1, 1, 3, 5, 17, "R2");
    // R5 reserved code leaves flags alone
    step(1, 1, 5, 6, 18, "R2");
    step(1, 3, 5, 6, 19, "R5");
    step(1, 0, 5, 6, 20, "R5");
    step(1, 3, 6, 7, 21, "R5");
    step(1, 0, 6, 7, 22, "R5");
    // R9 idle
    step(0, 1, 7, 0, 0, "R9");
    step(1, 0, 7, 0, 23, "R9");
    // R8 top address
    step(1, 1, NF - 1, 8, 24, "R8");
    step(1, 0, NF - 2, 8, 25, "R8");
    step(1, 1, NF - 1, 9, 26, "R6");
    step(1, 2, NF - 1, 9, 27, "R3");
    step(1, 1, NF - 1, 9, 28, "R2");
    // R7 mixed traffic
    for (int n = 0; n < 400; n++)
      step(($urandom % 5) != 0, int'($urandom % 4), int'($urandom % NF),
           int'($urandom % 16), int'($urandom % 64), "R7");
    step(0, 0, 0, 0, 0, "R9");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule